// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block merges four reset requests into one internal reset and records which of them fired. The requests are a power-on level, a brown-out level, an external pin level and a watchdog timeout that arrives as a single-cycle pulse. All inputs are already synchronised to the block clock. The internal reset `sys_rst` is asserted while any request is present and is then stretched by a fixed, parameterised number of clock cycles after the last request goes away. A request that arrives during the stretch restarts it.

The stretch is controlled by a three-state machine. `RST_HOLD` is entered on power-on (asynchronously) or from any state when a request is sampled high. Transition HOLD_TO_STRETCH is taken at the first clock edge where no request is high; it clears the cycle counter. In `RST_STRETCH` the counter advances once per cycle. Transition STRETCH_TO_HOLD restarts the sequence if a request reappears. Transition STRETCH_TO_OFF is taken when the counter reaches `TOUT_CYCLES-1`. In `RST_OFF` the internal reset is low. Transition OFF_TO_HOLD is taken on any new request. `sys_rst` is high in every state except `RST_OFF`.

A four-bit cause register can be read and cleared by software over a minimal bus: a write strobe with write data, and combinational read data. The register sits in the low nibble of the read word, and the upper bits read as zero. Software can only clear flags. Each flag is cleared by writing a zero to its bit position.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_req` is high (asynchronous), `sys_rst` is high and the read data equals 0x01: the power-on flag at bit 0 is set, and the flags at bits 3, 2 and 1 are cleared.
- R2: When `bod_req`, `ext_req` or `wdt_pulse` is high at a rising clock edge, `sys_rst` is high after that edge.
- R3: After the last rising edge at which any request (including the `por_req` level) was high, `sys_rst` stays high for exactly `TOUT_CYCLES` further edges and goes low at the edge after those. For a one-cycle watchdog pulse, the count therefore begins at the first edge after the pulse has fallen.
- R4: A request that arrives while the stretch is counting restarts the full stretch length, measured from that request.
- R5: A watchdog pulse sets bit 3, a brown-out request sets bit 2 and an external request sets bit 1. Each flag is set at the edge where its request is sampled high.
- R6: A write (`reg_wr` high) with a zero at bit k, for k = 0..3, clears flag k at that edge. A one at bit k leaves flag k unchanged, so software can never set a flag. Write data bits 7:4 are ignored.
- R7: If a request and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: `reg_rdata[3:0]` shows the flags with no added read latency. `reg_rdata[7:4]` always reads zero.
- R9: A flag keeps its value through resets from other sources. It changes only on power-on, its own request or a clearing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on request level, active high, asynchronous assert |
| bod_req | input | 1 | Brown-out request level, active high |
| ext_req | input | 1 | External pin reset request level, active high |
| wdt_pulse | input | 1 | Watchdog timeout, one-cycle pulse |
| reg_wr | input | 1 | Cause register write strobe |
| reg_wdata | input | DATA_W | Write data; a zero in bits 3:0 clears that flag |
| reg_rdata | output | DATA_W | Cause register read data |
| sys_rst | output | 1 | Stretched internal reset, active high |

## Verification
The stretch length is measured for each source separately, with request pulses of one to three cycles. This separates timing that counts from the release of a request from timing that counts from its start. A second request is injected at every possible offset inside the stretch window. This shows whether the counter restarts or continues, and whether the window ends off by one. The cause register is swept over every combination of simultaneous sources and every low-nibble write value, with varying upper write bits. This distinguishes clear-on-zero from clear-on-one and from software setting. A further pass drives a request and a clearing write in the same cycle, which decides which of the two wins.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [1:0] {
        RST_HOLD    = 2'd0,
        RST_STRETCH = 2'd1,
        RST_OFF     = 2'd2
    } rst_state_e;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_POR  = 0;
    localparam int FLAG_EXT  = 1;
    localparam int FLAG_BOD  = 2;
    localparam int FLAG_WDT  = 3;

endpackage

// File: rtl/rcc_stretch_fsm.sv
module rcc_stretch_fsm
    import rcc_pkg::*;
#(
    parameter int TOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic por_req,
    input  logic any_req,
    output logic rst_out
);

    localparam int CNT_W = (TOUT_CYCLES > 1) ? $clog2(TOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOUT_CYCLES - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            state_q <= RST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RST_HOLD: begin
                if (!any_req) begin
                    state_d = RST_STRETCH;
                    cnt_d   = '0;
                end
            end
            RST_STRETCH: begin
                if (any_req) begin
                    state_d = RST_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = RST_OFF;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RST_OFF: begin
                cnt_d = '0;
                if (any_req) begin
                    state_d = RST_HOLD;
                end
            end
            default: begin
                state_d = RST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_out = (state_q != RST_OFF);
    end

endmodule

// File: rtl/rcc_cause_flags.sv
module rcc_cause_flags
    import rcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_req,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic [NUM_FLAGS-1:0] clr_vec,
    output logic [NUM_FLAGS-1:0] flags_q
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        if (i == FLAG_POR) begin : g_por_bit
            // set only by the asynchronous power-on request
            always_ff @(posedge clk or posedge por_req) begin
                if (por_req) begin
                    flags_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flags_q[i] <= 1'b0;
                end
            end
        end else begin : g_src_bit
            // a set at the same edge as a clear takes priority
            always_ff @(posedge clk or posedge por_req) begin
                if (por_req) begin
                    flags_q[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    flags_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flags_q[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rcc_bus_port.sv
module rcc_bus_port
    import rcc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] clr_vec,
    output logic [DATA_W-1:0]    reg_rdata
);

    localparam int PAD_W = DATA_W - NUM_FLAGS;

    always_comb begin
        clr_vec   = {NUM_FLAGS{reg_wr}} & ~reg_wdata[NUM_FLAGS-1:0];
        reg_rdata = {{PAD_W{1'b0}}, flags};
    end

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int TOUT_CYCLES = 16,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              por_req,
    input  logic              bod_req,
    input  logic              ext_req,
    input  logic              wdt_pulse,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst
);

    logic                 any_req;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;

    always_comb begin
        any_req            = bod_req | ext_req | wdt_pulse;
        set_vec            = '0;
        set_vec[FLAG_EXT]  = ext_req;
        set_vec[FLAG_BOD]  = bod_req;
        set_vec[FLAG_WDT]  = wdt_pulse;
    end

    rcc_stretch_fsm #(.TOUT_CYCLES(TOUT_CYCLES)) u_fsm (
        .clk     (clk),
        .por_req (por_req),
        .any_req (any_req),
        .rst_out (sys_rst)
    );

    rcc_cause_flags u_flags (
        .clk     (clk),
        .por_req (por_req),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags)
    );

    rcc_bus_port #(.DATA_W(DATA_W)) u_bus (
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int TOUT_CYCLES = 16,
    parameter int DATA_W      = 8
) (
    input logic              clk,
    input logic              por_req,
    input logic              bod_req,
    input logic              ext_req,
    input logic              wdt_pulse,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sys_rst
);

    localparam int QW = $clog2(TOUT_CYCLES + 2) + 1;
    localparam logic [QW-1:0] Q_MAX = QW'(TOUT_CYCLES + 1);

    logic          req_any;
    logic [QW-1:0] quiet_q;

    assign req_any = bod_req | ext_req | wdt_pulse;

    // edges since the last request, saturating
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            quiet_q <= '0;
        end else if (req_any) begin
            quiet_q <= '0;
        end else if (quiet_q != Q_MAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    p_por_state_r1: assert property (@(posedge clk)
        por_req |-> (sys_rst && reg_rdata[3:0] == 4'b0001));

    p_req_asserts_r2: assert property (@(posedge clk) disable iff (por_req)
        req_any |=> sys_rst);

    // covers R4 as well: a new request zeroes the quiet count
    p_reset_window_r3: assert property (@(posedge clk) disable iff (por_req)
        sys_rst == (quiet_q <= QW'(TOUT_CYCLES)));

    p_wdt_set_r5: assert property (@(posedge clk) disable iff (por_req)
        wdt_pulse |=> reg_rdata[3]);

    p_bod_set_r5: assert property (@(posedge clk) disable iff (por_req)
        bod_req |=> reg_rdata[2]);

    p_ext_set_r5: assert property (@(posedge clk) disable iff (por_req)
        ext_req |=> reg_rdata[1]);

    p_clear_wdt_r6: assert property (@(posedge clk) disable iff (por_req)
        (reg_wr && !reg_wdata[3] && !wdt_pulse) |=> !reg_rdata[3]);

    p_clear_por_r6: assert property (@(posedge clk) disable iff (por_req)
        (reg_wr && !reg_wdata[0]) |=> !reg_rdata[0]);

    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (por_req)
        !reg_rdata[0] |=> !reg_rdata[0]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (por_req)
        (bod_req && reg_wr && !reg_wdata[2]) |=> reg_rdata[2]);

    p_hold_r9: assert property (@(posedge clk) disable iff (por_req)
        (!req_any && !reg_wr) |=> $stable(reg_rdata));

endmodule

bind reset_cause_ctrl rcc_checker #(
    .TOUT_CYCLES (TOUT_CYCLES),
    .DATA_W      (DATA_W)
) u_chk (
    .clk       (clk),
    .por_req   (por_req),
    .bod_req   (bod_req),
    .ext_req   (ext_req),
    .wdt_pulse (wdt_pulse),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sys_rst   (sys_rst)
);

// File: tb/tb_reset_cause_ctrl.sv
`timescale 1ns/1ps
module tb_reset_cause_ctrl;

    localparam int TOUT = 5;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          por_req = 1'b0;
    logic          bod_req = 1'b0;
    logic          ext_req = 1'b0;
    logic          wdt_pulse = 1'b0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          sys_rst;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    reset_cause_ctrl #(.TOUT_CYCLES(TOUT), .DATA_W(DW)) dut (
        .clk       (clk),
        .por_req   (por_req),
        .bod_req   (bod_req),
        .ext_req   (ext_req),
        .wdt_pulse (wdt_pulse),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_rst   (sys_rst)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // m[0]=external (flag bit 1), m[1]=brown-out (bit 2), m[2]=watchdog (bit 3)
    task automatic set_reqs(input logic [2:0] m);
        ext_req   = m[0];
        bod_req   = m[1];
        wdt_pulse = m[2];
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sys_rst) n++;
            else break;
        end
    endtask

    task automatic pulse(input logic [2:0] m, input int len, input string tag);
        @(negedge clk);
        set_reqs(m);
        @(negedge clk);
        check({tag, " R2 reset after request"}, int'(sys_rst), 1);
        repeat (len - 1) @(negedge clk);
        set_reqs(3'b000);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] exp4;
        #2 por_req = 1'b1;
        @(negedge clk);
        // R1: power-on state
        check("R1 reset during por", int'(sys_rst), 1);
        check("R1 flags during por", int'(reg_rdata), 8'h01);
        repeat (2) @(negedge clk);
        por_req = 1'b0;
        measure(n);
        check("R3 stretch after por", n, TOUT);
        check("R1 flags after por", int'(reg_rdata), 8'h01);

        // R2/R3/R5: each source, several lengths
        for (int s = 0; s < 3; s++) begin
            for (int len = 1; len <= 3; len++) begin
                if (s == 2 && len > 1) continue;
                wr(8'h00);
                pulse(3'(1 << s), len, "src");
                measure(n);
                check("R3 stretch length per source", n, TOUT);
                check("R5 flag set by source", int'(reg_rdata), (1 << (s + 1)));
            end
        end

        // R4: second request at every offset inside the window
        for (int k = 1; k <= TOUT; k++) begin
            pulse(3'b001, 1, "restart");
            for (int j = 0; j < k - 1; j++) begin
                @(negedge clk);
                check("R4 reset held before restart", int'(sys_rst), 1);
            end
            pulse(3'b010, 1, "restart");
            measure(n);
            check("R4 stretch restarted", n, TOUT);
        end

        // R5/R6/R8: all source mixes against all low-nibble writes
        for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 16; w++) begin
                wr(8'h00);
                check("R6 clear all", int'(reg_rdata), 0);
                @(negedge clk);
                set_reqs(3'(m));
                @(negedge clk);
                set_reqs(3'b000);
                check("R5 mixed set", int'(reg_rdata), m << 1);
                wr(DW'(((((m * 5 + w * 3) & 15)) << 4) | w));
                exp4 = 4'(m << 1) & 4'(w);
                check("R6/R8 write-zero clear, ones no effect", int'(reg_rdata), int'(exp4));
            end
        end

        // R7: set beats clear in the same cycle
        for (int m = 1; m < 8; m++) begin
            wr(8'h00);
            @(negedge clk);
            set_reqs(3'(m));
            reg_wr    = 1'b1;
            reg_wdata = 8'h00;
            @(negedge clk);
            set_reqs(3'b000);
            reg_wr = 1'b0;
            check("R7 set wins over clear", int'(reg_rdata), m << 1);
        end

        // R9: flags survive other sources
        wr(8'h00);
        pulse(3'b010, 1, "keep");
        pulse(3'b100, 1, "keep");
        measure(n);
        check("R9 brown-out flag kept through watchdog", int'(reg_rdata), 8'h0C);
        repeat (3) @(negedge clk);
        check("R9 flags stable while idle", int'(reg_rdata), 8'h0C);

        // R1: power-on in mid-operation
        por_req = 1'b1;
        @(negedge clk);
        check("R1 por clears source flags", int'(reg_rdata), 8'h01);
        check("R1 reset on second por", int'(sys_rst), 1);
        por_req = 1'b0;
        measure(n);
        check("R3 stretch after second por", n, TOUT);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule